// File: doc/BRIEF.md
# Sprite Priority Compositing Chain

The block lays up to eight hardware sprites over a stream of background pixels. It takes one pixel per clock. Each pixel comes with its raster column and line, a background colour, a bit marking it as foreground graphics, and a flag marking it as border. Eight identical stages are wired in a registered line. The stage for sprite 7 comes first and the stage for sprite 0 comes last. Each stage compares the raster position against its sprite's window and replaces the pixel where its sprite is opaque. It then hands the pixel to the next stage. Because a stage only ever talks to its neighbour, no stage depends on a wide priority mux.

Each sprite has its own inputs: position, colour, enable, a behind-foreground flag and one 24-bit row of bitmap bits for the current line. The supplier of those bits, normally a fetch unit, keeps them steady while a line is being drawn. Together with the pixel, the chain carries the original background colour, the foreground bit and a mask of sprites that are opaque at that pixel. From these, the far end of the chain finds sprite-to-sprite and sprite-to-foreground collisions. It holds them in two sticky registers, and a read strobe clears each register.

Top module: `sprite_chain`

## Requirements
- R1: While reset is low and after its release, `pix_out`, `ss_coll` and `sf_coll` are all zero until a sprite result reaches them.
- R2: The pixel result for inputs sampled at clock edge k appears on `pix_out` after edge k+7, so the total latency is 8 cycles (one per stage).
- R3: Sprite s covers raster columns `xpos`..`xpos`+23 and lines `ypos`..`ypos`+20, compared without wrap-around. Row bit 23 is the column at `xpos` and bit 0 is the column at `xpos`+23.
- R4: Inside its window, a sprite is opaque where its row bit is 1 and transparent where the bit is 0. A sprite whose enable is 0 is never opaque. Where no sprite is opaque, the output is the background colour.
- R5: Where several sprites are opaque, the lowest-numbered one decides the pixel.
- R6: If that sprite's behind flag is 1 and the foreground bit is 1, the output is the background colour. Otherwise the output is the sprite's colour. A behind sprite still hides higher-numbered sprites.
- R7: While `in_border` is 1, no sprite is opaque: the output is the background colour and no collision is recorded.
- R8: When two or more sprites are opaque at one pixel, bit s of `ss_coll` is set for every sprite s among them.
- R9: When a sprite is opaque on a pixel whose foreground bit is 1, its bit in `sf_coll` is set, whatever its behind flag.
- R10: Collision bits are updated one cycle after the pixel leaves (edge k+8) and stay set. A clear strobe at an edge empties the register there, but collisions arriving at that same edge are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_x | input | 9 | Raster column of the incoming pixel |
| ras_y | input | 8 | Raster line of the incoming pixel |
| bg_pix | input | 4 | Background colour |
| bg_fg | input | 1 | Background pixel is foreground graphics |
| in_border | input | 1 | Pixel lies in the border |
| spr_en | input | 8 | Per-sprite enable |
| spr_behind | input | 8 | Per-sprite behind-foreground flag |
| spr_xpos | input | 72 | Sprite columns, sprite s at bits s*9 upward |
| spr_ypos | input | 64 | Sprite lines, sprite s at bits s*8 upward |
| spr_color | input | 32 | Sprite colours, sprite s at bits s*4 upward |
| spr_bits | input | 192 | Current row bitmaps, sprite s at bits s*24 upward |
| clr_ss | input | 1 | Clear strobe for `ss_coll` |
| clr_sf | input | 1 | Clear strobe for `sf_coll` |
| pix_out | output | 4 | Composited pixel |
| ss_coll | output | 8 | Sticky sprite-to-sprite collision bits |
| sf_coll | output | 8 | Sticky sprite-to-foreground collision bits |

## Verification
If a stage forwards the pixel, mask or foreground bit wrongly, the error reaches `pix_out` 8 cycles after the offending input. The collision registers show it one cycle later. A stale mask bit shows up as a single-bit or misplaced collision flag. Because the registers are sticky, a wrong collision bit stays visible until the next clear strobe, so even a one-cycle fault stays observable. The sweeps cross every window edge, stacked overlaps, behind and front flags, border spans and the column wrap at 511. Each output is compared on every cycle.

// File: rtl/sprc_pkg.sv
// Shared defaults and helpers for the sprite compositing chain.
// Assumes at most 32 sprites, so a mask fits the helper's argument.
package sprc_pkg;
    localparam int unsigned SPR_COUNT  = 8;
    localparam int unsigned SPR_WIDTH  = 24;
    localparam int unsigned SPR_HEIGHT = 21;
    localparam int unsigned RAS_X_W    = 9;
    localparam int unsigned RAS_Y_W    = 8;
    localparam int unsigned PIX_W      = 4;

    // True when two or more bits of the mask are set.
    function automatic logic multi_hot(input logic [31:0] m);
        return (m & (m - 32'd1)) != 32'd0;
    endfunction
endpackage

// File: rtl/sprite_stage.sv
// One compositing stage. It tests its sprite's window and bitmap against the
// incoming raster position and overwrites the pixel where the sprite is
// opaque. It registers the whole pixel bundle toward the next stage.
// Assumes the configuration and row bits are stable while a line is drawn.
module sprite_stage #(
    parameter int unsigned XW  = 9,
    parameter int unsigned YW  = 8,
    parameter int unsigned CW  = 4,
    parameter int unsigned NS  = 8,
    parameter int unsigned SW  = 24,
    parameter int unsigned SH  = 21,
    parameter int unsigned IDX = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic          cfg_behind,
    input  logic [XW-1:0] cfg_x,
    input  logic [YW-1:0] cfg_y,
    input  logic [CW-1:0] cfg_col,
    input  logic [SW-1:0] cfg_bits,
    input  logic [XW-1:0] in_x,
    input  logic [YW-1:0] in_y,
    input  logic [CW-1:0] in_pix,
    input  logic [CW-1:0] in_bg,
    input  logic          in_fg,
    input  logic          in_brd,
    input  logic [NS-1:0] in_mask,
    output logic [XW-1:0] out_x,
    output logic [YW-1:0] out_y,
    output logic [CW-1:0] out_pix,
    output logic [CW-1:0] out_bg,
    output logic          out_fg,
    output logic          out_brd,
    output logic [NS-1:0] out_mask
);
    localparam int unsigned DXW = XW + 1;
    localparam int unsigned DYW = YW + 1;
    localparam int unsigned IW  = $clog2(SW);

    logic [DXW-1:0] dx;
    logic [DYW-1:0] dy;
    logic [IW-1:0]  bidx;
    logic           in_col, in_row, opaque;

    // Offsets into the sprite window; the extra top bit flags a negative offset.
    assign dx     = {1'b0, in_x} - {1'b0, cfg_x};
    assign dy     = {1'b0, in_y} - {1'b0, cfg_y};
    assign in_col = !dx[XW] && (dx < DXW'(SW));
    assign in_row = !dy[YW] && (dy < DYW'(SH));
    assign bidx   = IW'(SW - 1) - dx[IW-1:0];
    assign opaque = cfg_en && !in_brd && in_col && in_row && cfg_bits[bidx];

    // Register the bundle, drawing the sprite where it is opaque.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_x    <= '0;
            out_y    <= '0;
            out_pix  <= '0;
            out_bg   <= '0;
            out_fg   <= 1'b0;
            out_brd  <= 1'b0;
            out_mask <= '0;
        end else begin
            out_x    <= in_x;
            out_y    <= in_y;
            out_bg   <= in_bg;
            out_fg   <= in_fg;
            out_brd  <= in_brd;
            out_mask <= in_mask | (opaque ? (NS'(1) << IDX) : '0);
            out_pix  <= opaque ? ((cfg_behind && in_fg) ? in_bg : cfg_col) : in_pix;
        end
    end
endmodule

// File: rtl/sprite_coll_latch.sv
// Sticky collision registers at the end of the chain. They turn the final
// opaque mask and foreground bit into per-sprite collision bits.
// Assumes NS is at most 32.
module sprite_coll_latch
    import sprc_pkg::*;
#(
    parameter int unsigned NS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] hit_mask,
    input  logic          hit_fg,
    input  logic          clr_ss,
    input  logic          clr_sf,
    output logic [NS-1:0] ss_q,
    output logic [NS-1:0] sf_q
);
    logic [NS-1:0] ss_new, sf_new;

    // New hits on this pixel: overlaps of two or more sprites, and sprites on foreground.
    assign ss_new = multi_hot(32'(hit_mask)) ? hit_mask : '0;
    assign sf_new = hit_fg ? hit_mask : '0;

    // Accumulate hits; a clear strobe drops old bits but keeps this edge's hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_q <= '0;
            sf_q <= '0;
        end else begin
            ss_q <= (clr_ss ? '0 : ss_q) | ss_new;
            sf_q <= (clr_sf ? '0 : sf_q) | sf_new;
        end
    end
endmodule

// File: rtl/sprite_chain.sv
// Top of the sprite compositing chain. Stages run from sprite NS-1 at the
// input to sprite 0 at the output, so lower-numbered sprites land on top.
// Assumes sprite rows and configuration are held stable by the supplier.
module sprite_chain
    import sprc_pkg::*;
#(
    parameter int unsigned NS = SPR_COUNT,
    parameter int unsigned XW = RAS_X_W,
    parameter int unsigned YW = RAS_Y_W,
    parameter int unsigned CW = PIX_W,
    parameter int unsigned SW = SPR_WIDTH,
    parameter int unsigned SH = SPR_HEIGHT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XW-1:0]    ras_x,
    input  logic [YW-1:0]    ras_y,
    input  logic [CW-1:0]    bg_pix,
    input  logic             bg_fg,
    input  logic             in_border,
    input  logic [NS-1:0]    spr_en,
    input  logic [NS-1:0]    spr_behind,
    input  logic [NS*XW-1:0] spr_xpos,
    input  logic [NS*YW-1:0] spr_ypos,
    input  logic [NS*CW-1:0] spr_color,
    input  logic [NS*SW-1:0] spr_bits,
    input  logic             clr_ss,
    input  logic             clr_sf,
    output logic [CW-1:0]    pix_out,
    output logic [NS-1:0]    ss_coll,
    output logic [NS-1:0]    sf_coll
);
    logic [XW-1:0] b_x    [NS+1];
    logic [YW-1:0] b_y    [NS+1];
    logic [CW-1:0] b_pix  [NS+1];
    logic [CW-1:0] b_bg   [NS+1];
    logic          b_fg   [NS+1];
    logic          b_brd  [NS+1];
    logic [NS-1:0] b_mask [NS+1];

    // Chain head: raw background pixel with an empty sprite mask.
    assign b_x[0]    = ras_x;
    assign b_y[0]    = ras_y;
    assign b_pix[0]  = bg_pix;
    assign b_bg[0]   = bg_pix;
    assign b_fg[0]   = bg_fg;
    assign b_brd[0]  = in_border;
    assign b_mask[0] = '0;

    for (genvar p = 0; p < NS; p++) begin : g_stage
        localparam int unsigned S = NS - 1 - p;
        sprite_stage #(
            .XW(XW), .YW(YW), .CW(CW), .NS(NS), .SW(SW), .SH(SH), .IDX(S)
        ) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_en     (spr_en[S]),
            .cfg_behind (spr_behind[S]),
            .cfg_x      (spr_xpos[S*XW +: XW]),
            .cfg_y      (spr_ypos[S*YW +: YW]),
            .cfg_col    (spr_color[S*CW +: CW]),
            .cfg_bits   (spr_bits[S*SW +: SW]),
            .in_x       (b_x[p]),
            .in_y       (b_y[p]),
            .in_pix     (b_pix[p]),
            .in_bg      (b_bg[p]),
            .in_fg      (b_fg[p]),
            .in_brd     (b_brd[p]),
            .in_mask    (b_mask[p]),
            .out_x      (b_x[p+1]),
            .out_y      (b_y[p+1]),
            .out_pix    (b_pix[p+1]),
            .out_bg     (b_bg[p+1]),
            .out_fg     (b_fg[p+1]),
            .out_brd    (b_brd[p+1]),
            .out_mask   (b_mask[p+1])
        );
    end

    logic [NS-1:0] fin_mask;
    logic [CW-1:0] fin_bg;
    logic          fin_fg, fin_brd;
    logic [XW-1:0] fin_x_unused;
    logic [YW-1:0] fin_y_unused;

    // Chain tail as seen by the collision registers and the checker.
    assign fin_mask     = b_mask[NS];
    assign fin_bg       = b_bg[NS];
    assign fin_fg       = b_fg[NS];
    assign fin_brd      = b_brd[NS];
    assign fin_x_unused = b_x[NS];
    assign fin_y_unused = b_y[NS];
    assign pix_out      = b_pix[NS];

    sprite_coll_latch #(.NS(NS)) u_coll (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_mask (fin_mask),
        .hit_fg   (fin_fg),
        .clr_ss   (clr_ss),
        .clr_sf   (clr_sf),
        .ss_q     (ss_coll),
        .sf_q     (sf_coll)
    );
endmodule

// File: rtl/sprite_chain_chk.sv
// Property checker for sprite_chain, attached by bind below.
// Assumes it sees the chain tail bundle and the top-level ports.
module sprite_chain_chk #(
    parameter int unsigned NS = 8,
    parameter int unsigned CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NS-1:0] fin_mask,
    input logic          fin_fg,
    input logic          fin_brd,
    input logic [CW-1:0] fin_pix,
    input logic [CW-1:0] fin_bg,
    input logic          clr_ss,
    input logic          clr_sf,
    input logic [NS-1:0] ss_coll,
    input logic [NS-1:0] sf_coll
);
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ss_coll == '0 && sf_coll == '0));

    a_r7_border_no_sprite: assert property (@(posedge clk) disable iff (!rst_n)
        fin_brd |-> (fin_mask == '0));

    a_r4_empty_keeps_bg: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_mask == '0) |-> (fin_pix == fin_bg));

    a_r8_never_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |-> ($countones(ss_coll) != 1));

    a_r10_ss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_ss |=> ((ss_coll & $past(ss_coll)) == $past(ss_coll)));

    a_r10_sf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_sf |=> ((sf_coll & $past(sf_coll)) == $past(sf_coll)));

    a_r9_sf_needs_fg: assert property (@(posedge clk) disable iff (!rst_n)
        (!fin_fg && !clr_sf) |=> (sf_coll == $past(sf_coll)));
endmodule

bind sprite_chain sprite_chain_chk #(.NS(NS), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin_mask (fin_mask),
    .fin_fg   (fin_fg),
    .fin_brd  (fin_brd),
    .fin_pix  (pix_out),
    .fin_bg   (fin_bg),
    .clr_ss   (clr_ss),
    .clr_sf   (clr_sf),
    .ss_coll  (ss_coll),
    .sf_coll  (sf_coll)
);

// File: tb/tb_sprite_chain.sv
`timescale 1ns/1ps
module tb_sprite_chain;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [8:0]   ras_x = '0;
    logic [7:0]   ras_y = '0;
    logic [3:0]   bg_pix = '0;
    logic         bg_fg = 1'b0;
    logic         in_border = 1'b1;
    logic [7:0]   spr_en = '0;
    logic [7:0]   spr_behind = '0;
    logic [71:0]  spr_xpos = '0;
    logic [63:0]  spr_ypos = '0;
    logic [31:0]  spr_color = '0;
    logic [191:0] spr_bits = '0;
    logic         clr_ss = 1'b0;
    logic         clr_sf = 1'b0;
    logic [3:0]   pix_out;
    logic [7:0]   ss_coll, sf_coll;

    sprite_chain dut (.*);

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    int sx[8], sy[8], sc[8];
    bit se[8], sb[8];
    logic [23:0] sr[8];

    int e_pix[16];
    logic [7:0] h_ss[16], h_sf[16];
    logic [7:0] m_ss = '0, m_sf = '0;
    int cnum = 0;

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (call %0d)", tag, act, exp, cnum);
        end
    endtask

    task automatic apply_cfg();
        for (int s = 0; s < 8; s++) begin
            spr_en[s]          = se[s];
            spr_behind[s]      = sb[s];
            spr_xpos[s*9 +: 9] = sx[s][8:0];
            spr_ypos[s*8 +: 8] = sy[s][7:0];
            spr_color[s*4 +: 4] = sc[s][3:0];
            spr_bits[s*24 +: 24] = sr[s];
        end
    endtask

    // Reference model: lowest-numbered opaque sprite wins, then foreground rule.
    task automatic model(input int x, input int y, input int bg, input bit fg,
                         input bit brd, output int pix, output logic [7:0] m);
        int w;
        m = '0;
        w = -1;
        for (int s = 0; s < 8; s++) begin
            int dx, dy;
            dx = x - sx[s];
            dy = y - sy[s];
            if (se[s] && !brd && dx >= 0 && dx < 24 && dy >= 0 && dy < 21)
                if (sr[s][23-dx]) m[s] = 1'b1;
        end
        for (int s = 7; s >= 0; s--) if (m[s]) w = s;
        pix = bg;
        if (w >= 0) pix = (sb[w] && fg) ? bg : sc[w];
    endtask

    // One pixel per call: drive, predict, step an edge, compare outputs.
    task automatic px(input int x, input int y, input int bg, input bit fg,
                      input bit brd, input bit rs, input bit rf, input string tag);
        int p;
        logic [7:0] m;
        model(x, y, bg, fg, brd, p, m);
        e_pix[cnum % 16] = p;
        h_ss[cnum % 16]  = ($countones(m) >= 2) ? m : 8'h00;
        h_sf[cnum % 16]  = fg ? m : 8'h00;
        ras_x = x[8:0]; ras_y = y[7:0]; bg_pix = bg[3:0];
        bg_fg = fg; in_border = brd; clr_ss = rs; clr_sf = rf;
        m_ss = (rs ? 8'h00 : m_ss) | ((cnum >= 8) ? h_ss[(cnum-8) % 16] : 8'h00);
        m_sf = (rf ? 8'h00 : m_sf) | ((cnum >= 8) ? h_sf[(cnum-8) % 16] : 8'h00);
        @(negedge clk);
        if (cnum >= 7) chk(pix_out, e_pix[(cnum-7) % 16], {"R2 ", tag});
        chk(ss_coll, m_ss, "R8 R10 ss_coll");
        chk(sf_coll, m_sf, "R9 R10 sf_coll");
        cnum++;
    endtask

    task automatic drain();
        for (int i = 0; i < 9; i++) px(i, 0, i, 0, 1, 0, 0, "R7 drain");
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 8; s++) begin
            sx[s] = 0; sy[s] = 0; sc[s] = s + 1; se[s] = 0; sb[s] = 0; sr[s] = '1;
        end
        apply_cfg();
        repeat (3) @(negedge clk);
        chk(pix_out, 0, "R1 pix_out in reset");
        chk(ss_coll, 0, "R1 ss_coll in reset");
        chk(sf_coll, 0, "R1 sf_coll in reset");
        rst_n = 1'b1;

        // R4: disabled sprites never show, pixel is the background.
        for (int y = 0; y < 4; y++)
            for (int x = 0; x < 40; x++) px(x, y, (x + y) % 16, x[1], 0, 0, 0, "R4 disabled");
        drain();

        // R5 R6 R8 R9 R10: stacked overlapping sprites with mixed priority flags.
        for (int s = 0; s < 8; s++) begin
            sx[s] = 10 + 3 * s; sy[s] = 2 + s; sc[s] = 8 + s; se[s] = 1;
            sb[s] = (s % 3 == 1); sr[s] = ~(24'h111111 << s);
        end
        apply_cfg();
        for (int y = 0; y < 32; y++)
            for (int x = 0; x < 64; x++) begin
                int k;
                k = y * 64 + x;
                px(x, y, (x * 3 + y) % 16, x[3] ^ y[1], (x < 4) || (y == 30),
                   (k % 29) == 28, (k % 41) == 40, "R5 R6 overlap");
            end
        drain();
        // R10: clear strobes on an idle chain empty both registers.
        px(0, 0, 0, 0, 1, 1, 1, "R10 clear");
        drain();

        // R3: one sprite with only its edge columns set, swept across its window edges.
        for (int s = 0; s < 8; s++) se[s] = 0;
        se[3] = 1; sx[3] = 20; sy[3] = 5; sr[3] = 24'h800001; sb[3] = 0; sc[3] = 5;
        apply_cfg();
        for (int y = 3; y < 29; y++)
            for (int x = 15; x < 51; x++) px(x, y, 0, 0, 0, 0, 0, "R3 window edges");
        drain();

        // R3: window near the column and line limits must not wrap.
        se[3] = 0; se[0] = 1; sx[0] = 500; sy[0] = 250; sr[0] = '1; sc[0] = 9;
        apply_cfg();
        for (int yi = 0; yi < 8; yi++) begin
            int y;
            y = (250 + yi) % 256;
            for (int x = 495; x < 512; x++) px(x, y, 2, 0, 0, 0, 0, "R3 no wrap");
            for (int x = 0; x < 6; x++) px(x, y, 2, 0, 0, 0, 0, "R3 no wrap");
        end
        drain();

        // R7: border held over all sprites in full view.
        for (int s = 0; s < 8; s++) begin
            se[s] = 1; sx[s] = 8; sy[s] = 0; sr[s] = '1; sb[s] = 0;
        end
        apply_cfg();
        for (int x = 0; x < 40; x++) px(x, 3, 1, x[0], 1, 0, 0, "R7 border");
        drain();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule